// File: doc/BRIEF.md
# Segment Access Micro-Op Sequencer

This block takes one vector segment load or store instruction and turns it into a stream of micro-operation descriptors. Each descriptor names one destination or source vector register of one field. The caller pulses a start input with the base register number, the field count, the vector length and the element width. The sequencer then presents descriptors one at a time on a valid/ready handshake. The walk is field-major: every register of field 0 comes first, then every register of field 1, and so on. Each descriptor carries the field number, the register offset inside that field, the absolute vector register, the number of elements that register holds, and flags that mark the first and the last descriptor.

Before it emits anything, the sequencer checks whether the whole register group fits inside the register file. If any descriptor would name a register beyond the top, the instruction is illegal. In that case the normal stream is never produced. In its place comes a single faulting no-op that is marked both first and last. Address generation and data movement belong to the consumer of the descriptors.

Top module: `seg_uop_seq`

## Requirements
- R1: After reset `uop_valid_o` is low, and it stays low until a start pulse with a non-zero vector length arrives.
- R2: Let lanes = VLEN / (8 << `eew_i`), where code 0 means 8-bit, 1 means 16-bit, 2 means 32-bit and 3 means 64-bit elements. In a normal stream, the descriptor with register offset i carries `uop_elems_o` = min(vl − i·lanes, lanes), recomputed from the full vl in every field.
- R3: Let per = ceil(vl / lanes) and fields = `nf_i` + 1. A legal instruction with vl > 0 yields exactly fields·per descriptors. They come in the order field 0..fields−1, and inside each field in register offset 0..per−1. `uop_field_o` and `uop_idx_o` report the field and the offset. After start, and after each accepted descriptor except the last, the next descriptor is presented in the following cycle.
- R4: In a normal stream, `uop_vreg_o` = base + offset + field·per.
- R5: `uop_first_o` is set only on the first descriptor and `uop_last_o` only on the last. Once the last one is accepted, valid drops in the next cycle.
- R6: If vl > 0 and base + fields·per > 32, exactly one descriptor is emitted with `uop_fault_o`=1, first=1, last=1, field 0, offset 0, elems 0 and vreg = base. A group that ends exactly at register 31 is legal. Normal descriptors have `uop_fault_o`=0.
- R7: While `uop_valid_o` is high and `uop_ready_i` is low, every descriptor output holds its value.
- R8: A start pulse that arrives while a stream or fault no-op is pending is ignored. The pending stream continues unchanged, and no new stream follows.
- R9: A start pulse with vl = 0 produces no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin sequencing one instruction |
| base_i | input | 5 | Base vector register number |
| nf_i | input | 3 | Field count minus one |
| vl_i | input | VL_W | Vector length in elements |
| eew_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| uop_valid_o | output | 1 | Descriptor present |
| uop_ready_i | input | 1 | Consumer accepts descriptor |
| uop_fault_o | output | 1 | Descriptor is an illegal-instruction no-op |
| uop_field_o | output | 3 | Field number |
| uop_idx_o | output | VL_W | Register offset inside the field |
| uop_vreg_o | output | 5 | Absolute vector register |
| uop_elems_o | output | VL_W | Elements covered by this register |
| uop_first_o | output | 1 | First descriptor of the instruction |
| uop_last_o | output | 1 | Last descriptor of the instruction |

## Verification
The bench sweeps every element width and every field count against a spread of bases and lengths. This reaches lengths that end partway through a register, where a design that reuses a decremented count across fields would report a short final field. It drives base and group-size pairs on both sides of the register-file top. A sequencer that checks only the first register, or that compares with an off-by-one bound, would either stream past register 31 or fault a group that fits exactly. Random backpressure and a stray start pulse in mid-stream expose descriptors that change while stalled, or a stream that restarts. A zero-length start reveals a design that emits a spurious element-less descriptor.

// File: rtl/seg_uop_pkg.sv
package seg_uop_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_FAULT = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic fault;
        logic first;
        logic last;
    } uop_tag_t;

    // elements held by one register for a given width code
    function automatic int unsigned lanes_for(input int unsigned vlen, input logic [1:0] ew);
        return (vlen / 8) >> ew;
    endfunction

endpackage

// File: rtl/seg_uop_plan.sv
module seg_uop_plan
    import seg_uop_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREG  = 32,
    parameter int NF_W  = 3,
    parameter int VL_W  = 8,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic [REG_W-1:0] base_i,
    input  logic [NF_W-1:0]  nf_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [1:0]       eew_i,
    output logic [VL_W-1:0]  lanes_o,
    output logic [VL_W-1:0]  per_o,
    output logic             ovf_o
);
    localparam int LG     = $clog2(VLEN / 8);
    localparam int SPAN_W = REG_W + NF_W + VL_W + 2;

    logic [VL_W:0]     padded;
    logic [3:0]        shamt;
    logic [SPAN_W-1:0] span;

    always_comb begin
        lanes_o = VL_W'(lanes_for(VLEN, eew_i));
        shamt   = 4'(LG) - 4'(eew_i);
        padded  = (VL_W+1)'(vl_i) + (VL_W+1)'(lanes_o) - (VL_W+1)'(1);
        per_o   = VL_W'(padded >> shamt);
        span    = SPAN_W'(base_i) + (SPAN_W'(nf_i) + SPAN_W'(1)) * SPAN_W'(per_o);
        ovf_o   = (vl_i != '0) && (span > SPAN_W'(NREG));
    end
endmodule

// File: rtl/seg_uop_ctrl.sv
module seg_uop_ctrl
    import seg_uop_pkg::*;
#(
    parameter int NF_W  = 3,
    parameter int VL_W  = 8,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [REG_W-1:0] base_i,
    input  logic [NF_W-1:0]  nf_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [VL_W-1:0]  lanes_i,
    input  logic [VL_W-1:0]  per_i,
    input  logic             ovf_i,
    input  logic             ready_i,
    output sq_state_e        state_o,
    output logic [NF_W-1:0]  field_o,
    output logic [VL_W-1:0]  idx_o,
    output logic [REG_W-1:0] vreg_o,
    output logic [VL_W-1:0]  rem_o,
    output logic [VL_W-1:0]  lanes_o,
    output logic             first_o,
    output logic             last_o
);
    sq_state_e        st_q;
    logic [NF_W-1:0]  nf_q, f_q;
    logic [VL_W-1:0]  vl_q, lanes_q, per_q, i_q, rem_q;
    logic [REG_W-1:0] vreg_q;
    logic             end_of_field;

    assign end_of_field = (i_q == per_q - VL_W'(1));
    assign first_o      = (f_q == '0) && (i_q == '0);
    assign last_o       = (f_q == nf_q) && end_of_field;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            nf_q    <= '0;
            f_q     <= '0;
            vl_q    <= '0;
            lanes_q <= '0;
            per_q   <= '0;
            i_q     <= '0;
            rem_q   <= '0;
            vreg_q  <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (start_i && vl_i != '0) begin
                        st_q    <= ovf_i ? SQ_FAULT : SQ_RUN;
                        nf_q    <= nf_i;
                        vl_q    <= vl_i;
                        lanes_q <= lanes_i;
                        per_q   <= per_i;
                        f_q     <= '0;
                        i_q     <= '0;
                        rem_q   <= vl_i;
                        vreg_q  <= base_i;
                    end
                end
                SQ_RUN: begin
                    if (ready_i) begin
                        if (last_o) begin
                            st_q <= SQ_IDLE;
                        end else begin
                            vreg_q <= vreg_q + REG_W'(1);
                            if (end_of_field) begin
                                i_q   <= '0;
                                f_q   <= f_q + NF_W'(1);
                                rem_q <= vl_q;
                            end else begin
                                i_q   <= i_q + VL_W'(1);
                                rem_q <= rem_q - lanes_q;
                            end
                        end
                    end
                end
                SQ_FAULT: begin
                    if (ready_i) st_q <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign state_o = st_q;
    assign field_o = f_q;
    assign idx_o   = i_q;
    assign vreg_o  = vreg_q;
    assign rem_o   = rem_q;
    assign lanes_o = lanes_q;
endmodule

// File: rtl/seg_uop_fmt.sv
module seg_uop_fmt
    import seg_uop_pkg::*;
#(
    parameter int NF_W  = 3,
    parameter int VL_W  = 8,
    parameter int REG_W = 5
) (
    input  sq_state_e        state_i,
    input  logic [NF_W-1:0]  field_i,
    input  logic [VL_W-1:0]  idx_i,
    input  logic [REG_W-1:0] vreg_i,
    input  logic [VL_W-1:0]  rem_i,
    input  logic [VL_W-1:0]  lanes_i,
    input  logic             first_i,
    input  logic             last_i,
    output logic             valid_o,
    output uop_tag_t         tag_o,
    output logic [NF_W-1:0]  field_o,
    output logic [VL_W-1:0]  idx_o,
    output logic [REG_W-1:0] vreg_o,
    output logic [VL_W-1:0]  elems_o
);
    always_comb begin
        valid_o = (state_i != SQ_IDLE);
        field_o = '0;
        idx_o   = '0;
        vreg_o  = vreg_i;
        elems_o = '0;
        tag_o   = '{fault: 1'b0, first: 1'b0, last: 1'b0};
        if (state_i == SQ_FAULT) begin
            tag_o = '{fault: 1'b1, first: 1'b1, last: 1'b1};
        end else if (state_i == SQ_RUN) begin
            field_o = field_i;
            idx_o   = idx_i;
            elems_o = (rem_i < lanes_i) ? rem_i : lanes_i;
            tag_o   = '{fault: 1'b0, first: first_i, last: last_i};
        end
    end
endmodule

// File: rtl/seg_uop_seq.sv
module seg_uop_seq
    import seg_uop_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREG  = 32,
    parameter int NF_W  = 3,
    parameter int VL_W  = 8,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [REG_W-1:0] base_i,
    input  logic [NF_W-1:0]  nf_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [1:0]       eew_i,
    output logic             uop_valid_o,
    input  logic             uop_ready_i,
    output logic             uop_fault_o,
    output logic [NF_W-1:0]  uop_field_o,
    output logic [VL_W-1:0]  uop_idx_o,
    output logic [REG_W-1:0] uop_vreg_o,
    output logic [VL_W-1:0]  uop_elems_o,
    output logic             uop_first_o,
    output logic             uop_last_o
);
    logic [VL_W-1:0]  lanes_c, per_c, lanes_q, idx_q, rem_q;
    logic             ovf_c, first_q, last_q;
    logic [NF_W-1:0]  field_q;
    logic [REG_W-1:0] vreg_q;
    sq_state_e        state_q;
    uop_tag_t         tag;

    seg_uop_plan #(.VLEN(VLEN), .NREG(NREG), .NF_W(NF_W), .VL_W(VL_W), .REG_W(REG_W)) u_plan (
        .base_i(base_i), .nf_i(nf_i), .vl_i(vl_i), .eew_i(eew_i),
        .lanes_o(lanes_c), .per_o(per_c), .ovf_o(ovf_c)
    );

    seg_uop_ctrl #(.NF_W(NF_W), .VL_W(VL_W), .REG_W(REG_W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .nf_i(nf_i),
        .vl_i(vl_i), .lanes_i(lanes_c), .per_i(per_c), .ovf_i(ovf_c),
        .ready_i(uop_ready_i), .state_o(state_q), .field_o(field_q), .idx_o(idx_q),
        .vreg_o(vreg_q), .rem_o(rem_q), .lanes_o(lanes_q),
        .first_o(first_q), .last_o(last_q)
    );

    seg_uop_fmt #(.NF_W(NF_W), .VL_W(VL_W), .REG_W(REG_W)) u_fmt (
        .state_i(state_q), .field_i(field_q), .idx_i(idx_q), .vreg_i(vreg_q),
        .rem_i(rem_q), .lanes_i(lanes_q), .first_i(first_q), .last_i(last_q),
        .valid_o(uop_valid_o), .tag_o(tag), .field_o(uop_field_o),
        .idx_o(uop_idx_o), .vreg_o(uop_vreg_o), .elems_o(uop_elems_o)
    );

    assign uop_fault_o = tag.fault;
    assign uop_first_o = tag.first;
    assign uop_last_o  = tag.last;
endmodule

// File: rtl/seg_uop_seq_chk.sv
module seg_uop_seq_chk #(
    parameter int VLEN  = 128,
    parameter int NF_W  = 3,
    parameter int VL_W  = 8,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             uop_valid_o,
    input logic             uop_ready_i,
    input logic             uop_fault_o,
    input logic [NF_W-1:0]  uop_field_o,
    input logic [VL_W-1:0]  uop_idx_o,
    input logic [REG_W-1:0] uop_vreg_o,
    input logic [VL_W-1:0]  uop_elems_o,
    input logic             uop_first_o,
    input logic             uop_last_o
);
    localparam int MAX_LANES = VLEN / 8;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !uop_valid_o);

    assert_elems_range_R2: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && !uop_fault_o) |-> (uop_elems_o != '0 && int'(uop_elems_o) <= MAX_LANES));

    assert_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && uop_ready_i && !uop_last_o) |=> uop_valid_o);

    assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && uop_ready_i && uop_last_o) |=> !uop_valid_o);

    assert_fault_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && uop_fault_o) |-> (uop_first_o && uop_last_o && uop_elems_o == '0
                                          && uop_field_o == '0 && uop_idx_o == '0));

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_fault_o)
            && $stable(uop_field_o) && $stable(uop_idx_o) && $stable(uop_vreg_o)
            && $stable(uop_elems_o) && $stable(uop_first_o) && $stable(uop_last_o)));
endmodule

bind seg_uop_seq seg_uop_seq_chk #(.VLEN(VLEN), .NF_W(NF_W), .VL_W(VL_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_seg_uop_seq.sv
module tb_seg_uop_seq;
    localparam int VLEN = 128;
    localparam int VL_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [4:0]      base_i = '0;
    logic [2:0]      nf_i = '0;
    logic [VL_W-1:0] vl_i = '0;
    logic [1:0]      eew_i = '0;
    logic            uop_ready_i = 1'b0;
    logic            uop_valid_o, uop_fault_o, uop_first_o, uop_last_o;
    logic [2:0]      uop_field_o;
    logic [VL_W-1:0] uop_idx_o, uop_elems_o;
    logic [4:0]      uop_vreg_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    seg_uop_seq #(.VLEN(VLEN), .VL_W(VL_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .nf_i(nf_i),
        .vl_i(vl_i), .eew_i(eew_i), .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
        .uop_fault_o(uop_fault_o), .uop_field_o(uop_field_o), .uop_idx_o(uop_idx_o),
        .uop_vreg_o(uop_vreg_o), .uop_elems_o(uop_elems_o),
        .uop_first_o(uop_first_o), .uop_last_o(uop_last_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] snap();
        return {uop_fault_o, uop_field_o, uop_idx_o, uop_vreg_o, uop_elems_o, uop_first_o, uop_last_o};
    endfunction

    task automatic run(input int base, input int nf, input int vl, input int eew);
        int lanes, per, nfld, total, k, cyc, f, i, e;
        bit ovf, held, poked;
        logic [31:0] kept;
        lanes = (VLEN / 8) >> eew;
        per   = (vl + lanes - 1) / lanes;
        nfld  = nf + 1;
        ovf   = (vl != 0) && (base + nfld * per > 32);
        total = (vl == 0) ? 0 : (ovf ? 1 : nfld * per);
        @(negedge clk);
        start_i = 1'b1; base_i = 5'(base); nf_i = 3'(nf); vl_i = VL_W'(vl); eew_i = 2'(eew);
        uop_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; cyc = 0; held = 0; poked = 0; kept = '0;
        while (k < total && cyc < 4000) begin
            if (held) begin
                chk(snap() == kept, "R7 hold under stall", int'(snap()), int'(kept));
                held = 0;
            end
            if (!poked && k == 1 && total > 2) begin
                start_i = 1'b1; base_i = 5'd0; nf_i = 3'd0; vl_i = VL_W'(1); poked = 1;
            end else begin
                start_i = 1'b0;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            uop_ready_i = lfsr[0] | lfsr[1];
            chk(uop_valid_o == 1'b1, "R3 descriptor presented", int'(uop_valid_o), 1);
            if (uop_valid_o) begin
                if (uop_ready_i) begin
                    if (ovf) begin
                        chk(uop_fault_o == 1'b1, "R6 fault flag", int'(uop_fault_o), 1);
                        chk(uop_first_o && uop_last_o, "R6 first and last", int'({uop_first_o, uop_last_o}), 3);
                        chk(int'(uop_vreg_o) == base, "R6 vreg", int'(uop_vreg_o), base);
                        chk(uop_elems_o == '0 && uop_field_o == '0 && uop_idx_o == '0,
                            "R6 zero fields", int'(uop_elems_o), 0);
                    end else begin
                        f = k / per; i = k % per;
                        e = vl - i * lanes; if (e > lanes) e = lanes;
                        chk(uop_fault_o == 1'b0, "R6 no fault on legal", int'(uop_fault_o), 0);
                        chk(int'(uop_field_o) == f, "R3 field", int'(uop_field_o), f);
                        chk(int'(uop_idx_o) == i, "R3 offset", int'(uop_idx_o), i);
                        chk(int'(uop_vreg_o) == base + i + f * per, "R4 vreg", int'(uop_vreg_o), base + i + f * per);
                        chk(int'(uop_elems_o) == e, "R2 elems", int'(uop_elems_o), e);
                        chk(uop_first_o == (k == 0), "R5 first", int'(uop_first_o), int'(k == 0));
                        chk(uop_last_o == (k == total - 1), "R5 last", int'(uop_last_o), int'(k == total - 1));
                    end
                    k++;
                end else begin
                    held = 1;
                    kept = snap();
                end
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        uop_ready_i = 1'b1;
        if (poked) chk(k == total, "R8 count with stray start", k, total);
        else       chk(k == total, "R3 count", k, total);
        repeat (2) @(negedge clk);
        if (vl == 0) chk(uop_valid_o == 1'b0, "R9 zero length silent", int'(uop_valid_o), 0);
        else if (poked) chk(uop_valid_o == 1'b0, "R8 no restart", int'(uop_valid_o), 0);
        else chk(uop_valid_o == 1'b0, "R5 idle after last", int'(uop_valid_o), 0);
        uop_ready_i = 1'b0;
    endtask

    initial begin
        int vls[6];
        int bases[4];
        vls   = '{0, 1, 5, 16, 33, 128};
        bases = '{0, 3, 17, 31};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(uop_valid_o == 1'b0, "R1 idle after reset", int'(uop_valid_o), 0);
        // R6 boundary: group ending exactly at register 31, then one past it
        run(24, 7, 1, 0);
        run(25, 7, 1, 0);
        run(0, 1, 128, 1);
        run(1, 1, 128, 1);
        // R2 partial tail register in every field
        run(2, 2, 37, 2);
        for (int ew = 0; ew < 4; ew++)
            for (int nf = 0; nf < 8; nf++)
                for (int b = 0; b < 4; b++)
                    for (int v = 0; v < 6; v++)
                        run(bases[b], nf, vls[v], ew);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule